// File: doc/BRIEF.md
# Area-Based DMA Wait-State Controller

This block lengthens DMA bus cycles so that slow memory can be reached without changing the DMA engine. Two programmable boundary values split the physical address space into three areas: low, middle and high. Each area has its own 3-bit wait count. At the end of the second bus state of each DMA cycle, the block decodes the cycle address into an area. It then holds the bus-state sequencer in wait states before the third bus state. A hardware wait line can stretch the same window further.

The sequencer uses a plain control handshake. It pulses `t2_end` on the last clock of T2. From the next clock on, it treats every clock with `extend` high as a wait state. The first clock with `extend` low is T3. The `extend` output is the only back-pressure the block applies, and nothing at its edge is buffered.

The block is configured through a write-only register port:

| Address | Register |
|---|---|
| 0 | Lowest top byte of the middle area |
| 1 | Lowest top byte of the high area |
| 2 | Low-area wait count |
| 3 | Middle-area wait count |
| 4 | High-area wait count |

Top module: `dma_wait_ctrl`

## Requirements
- R1: After reset, both boundaries and all three wait counts are zero. `extend` is low, and a DMA cycle to any address gets zero wait states.
- R2: The area is chosen from address bits [23:16]. The top byte is high when it is at or above the high boundary (register 1). Otherwise it is middle when at or above the middle boundary (register 0). Otherwise it is low. The high test wins even when the high boundary is below the middle boundary.
- R3: With `wait_in` low, the number of clocks with `extend` high after a `t2_end` pulse equals the wait count of the decoded area. That count can be any value from 0 to 7.
- R4: `extend` is low whenever no DMA cycle is between T2 and T3. `wait_in` has no effect outside that window.
- R5: Within the window, `extend` stays high while `wait_in` is high. Every wait state also consumes one programmed wait. With `wait_in` high for the first N states, the cycle therefore gets max(N, count) wait states.
- R6: The area and count are latched on the clock where `t2_end` is high. A write that lands on that same clock or during the wait states takes effect from the next DMA cycle only.
- R7: A `t2_end` pulse that arrives while a cycle is still in wait states is ignored, and the running count is not reloaded.
- R8: Writes to addresses 5 to 7 change no register. Count writes keep only data bits [2:0], so writing 0xFF sets the count to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select (0..4 mapped) |
| cfg_wdata | input | 8 | Register write data |
| cyc_addr | input | 24 | Physical address of the current DMA cycle, valid with `t2_end` |
| t2_end | input | 1 | Pulse on the last clock of T2 |
| wait_in | input | 1 | Active-high hardware wait request |
| extend | output | 1 | High: the current state is a wait state; low: proceed to T3 |

## Verification
If a boundary or count register is corrupted, the fault shows up on the very next DMA cycle to the affected area as a wrong number of `extend` clocks. If the down-counter or the busy flag is wrong, the fault shows up within the same cycle: `extend` either stays high past the expected T3 or falls too early. If the counter reloads mid-window, or the flag leaks out of the window, the cycle gets extra wait states or `extend` goes high with no preceding `t2_end`, and this shows within one clock. The tests count wait states per cycle at the port for each area, each boundary edge and each wait-line overlap.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } dwc_state_e;

  function automatic int unsigned dwc_regs(input int unsigned areas);
    return (areas - 1) + areas;
  endfunction
endpackage

// File: rtl/dwc_regfile.sv
module dwc_regfile #(
  parameter int unsigned NUM_AREAS = 3,
  parameter int unsigned BND_W     = 8,
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned REG_AW    = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 we_i,
  input  logic [REG_AW-1:0]                    addr_i,
  input  logic [DATA_W-1:0]                    wdata_i,
  output logic [NUM_AREAS-2:0][BND_W-1:0]      bnd_o,
  output logic [NUM_AREAS-1:0][CNT_W-1:0]      cnt_o
);
  localparam int unsigned NUM_BND  = NUM_AREAS - 1;
  localparam int unsigned NUM_REGS = dwc_pkg::dwc_regs(NUM_AREAS);

  for (genvar b = 0; b < NUM_BND; b++) begin : g_bnd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bnd_o[b] <= '0;
      else if (we_i && addr_i == REG_AW'(b))
        bnd_o[b] <= wdata_i[BND_W-1:0];
    end
  end

  for (genvar a = 0; a < NUM_AREAS; a++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt_o[a] <= '0;
      else if (we_i && addr_i == REG_AW'(NUM_BND + a))
        cnt_o[a] <= wdata_i[CNT_W-1:0];
    end
  end

  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && 32'(addr_i) >= NUM_REGS) |=> ($stable(bnd_o) && $stable(cnt_o))); // R8
endmodule

// File: rtl/dwc_area_decode.sv
module dwc_area_decode #(
  parameter int unsigned NUM_AREAS = 3,
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned BND_W     = 8,
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned AREA_W    = $clog2(NUM_AREAS)
) (
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [NUM_AREAS-2:0][BND_W-1:0]  bnd_i,
  input  logic [NUM_AREAS-1:0][CNT_W-1:0]  cnt_i,
  output logic [AREA_W-1:0]                area_o,
  output logic [CNT_W-1:0]                 sel_cnt_o
);
  logic [BND_W-1:0] top_byte;
  logic [ADDR_W-BND_W-1:0] unused_low_bits;

  assign top_byte        = addr_i[ADDR_W-1 -: BND_W];
  assign unused_low_bits = addr_i[ADDR_W-BND_W-1:0];

  // Highest matching boundary wins, so area N overrides every lower one.
  always_comb begin
    area_o = '0;
    for (int unsigned i = 1; i < NUM_AREAS; i++) begin
      if (top_byte >= bnd_i[i-1])
        area_o = AREA_W'(i);
    end
  end

  assign sel_cnt_o = cnt_i[area_o];
endmodule

// File: rtl/dwc_wait_fsm.sv
module dwc_wait_fsm #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             t2_end_i,
  input  logic             wait_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  output logic             busy_o,
  output logic             extend_o
);
  import dwc_pkg::*;

  dwc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy_o   = (state_q == ST_HOLD);
  assign extend_o = busy_o && ((cnt_q != '0) || wait_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (t2_end_i) begin
            state_q <= ST_HOLD;
            cnt_q   <= load_cnt_i;
          end
        end
        ST_HOLD: begin
          if (extend_o) begin
            if (cnt_q != '0)
              cnt_q <= cnt_q - CNT_W'(1);
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && $past(extend_o) && $past(cnt_q) != '0) |-> cnt_q == $past(cnt_q) - CNT_W'(1)); // R3
  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && busy_o) |-> cnt_q <= $past(cnt_q)); // R7
  AST_T3_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !extend_o) |=> !busy_o); // R3
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && $past(wait_i)) |-> busy_o); // R5
endmodule

// File: rtl/dma_wait_ctrl.sv
module dma_wait_ctrl #(
  parameter int unsigned NUM_AREAS = 3,
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned BND_W     = 8,
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned REG_AW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              t2_end,
  input  logic              wait_in,
  output logic              extend
);
  localparam int unsigned AREA_W = $clog2(NUM_AREAS);

  logic [NUM_AREAS-2:0][BND_W-1:0] bnd;
  logic [NUM_AREAS-1:0][CNT_W-1:0] cnt;
  logic [AREA_W-1:0]               area;
  logic [CNT_W-1:0]                sel_cnt;
  logic                            busy;

  dwc_regfile #(
    .NUM_AREAS(NUM_AREAS), .BND_W(BND_W), .CNT_W(CNT_W),
    .DATA_W(DATA_W), .REG_AW(REG_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .bnd_o(bnd), .cnt_o(cnt)
  );

  dwc_area_decode #(
    .NUM_AREAS(NUM_AREAS), .ADDR_W(ADDR_W), .BND_W(BND_W),
    .CNT_W(CNT_W), .AREA_W(AREA_W)
  ) u_decode (
    .addr_i(cyc_addr), .bnd_i(bnd), .cnt_i(cnt),
    .area_o(area), .sel_cnt_o(sel_cnt)
  );

  dwc_wait_fsm #(
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .t2_end_i(t2_end), .wait_i(wait_in),
    .load_cnt_i(sel_cnt), .busy_o(busy), .extend_o(extend)
  );

  AST_HIGH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_addr[ADDR_W-1 -: BND_W] >= bnd[NUM_AREAS-2]) |-> 32'(area) == NUM_AREAS - 1); // R2
  AST_LOW_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_addr[ADDR_W-1 -: BND_W] < bnd[0] && cyc_addr[ADDR_W-1 -: BND_W] < bnd[NUM_AREAS-2])
      |-> area == '0); // R2
  AST_EXT_AFTER_T2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(extend) |-> $past(t2_end)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> !extend); // R4
endmodule

// File: tb/sim_dma_wait_ctrl.sv
`timescale 1ns/100ps
module sim_dma_wait_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [23:0] cyc_addr = '0;
  logic        t2_end = 1'b0;
  logic        wait_in = 1'b0;
  logic        extend;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_wait_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cyc_addr(cyc_addr), .t2_end(t2_end),
    .wait_in(wait_in), .extend(extend)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Run one DMA cycle; wait_in is high for the first wn states after T2.
  // mid_wr: perform a write of (wa,wd) during the first wait state.
  // same_wr: perform that write on the t2_end clock instead.
  task automatic dma_cycle(input logic [23:0] addr, input int wn,
                           input bit same_wr, input bit mid_wr, input bit dbl_t2,
                           input logic [2:0] wa, input logic [7:0] wd,
                           output int nwait);
    nwait = 0;
    @(negedge clk);
    cyc_addr = addr; t2_end = 1'b1;
    if (same_wr) begin cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd; end
    @(negedge clk);
    t2_end = 1'b0; cfg_we = 1'b0;
    for (int i = 0; i < 64; i++) begin
      wait_in = (i < wn);
      if (i == 0 && mid_wr) begin cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd; end
      if (i == 1 && dbl_t2) begin t2_end = 1'b1; cyc_addr = 24'hFF0000; end
      #0.5;
      if (!extend) break;
      nwait++;
      @(negedge clk);
      cfg_we = 1'b0; t2_end = 1'b0;
    end
    wait_in = 1'b0; cfg_we = 1'b0; t2_end = 1'b0;
    @(negedge clk);
  endtask

  task automatic plain(input logic [23:0] addr, output int n);
    dma_cycle(addr, 0, 1'b0, 1'b0, 1'b0, 3'd0, 8'd0, n);
  endtask

  task automatic t_reset();
    int n;
    check("R1 extend after reset", int'(extend), 0);
    plain(24'h000000, n); check("R1 low waits at reset", n, 0);
    plain(24'h7F1234, n); check("R1 mid waits at reset", n, 0);
    plain(24'hFFFFFF, n); check("R1 high waits at reset", n, 0);
  endtask

  task automatic t_idle_wait();
    @(negedge clk);
    wait_in = 1'b1;
    repeat (3) begin
      @(negedge clk); #0.5;
      check("R4 extend in idle with wait_in high", int'(extend), 0);
    end
    wait_in = 1'b0;
  endtask

  task automatic t_areas();
    int n;
    wr(3'd0, 8'h40); wr(3'd1, 8'hA0);
    wr(3'd2, 8'd1); wr(3'd3, 8'd4); wr(3'd4, 8'd7);
    plain(24'h000000, n); check("R2 low at zero", n, 1);
    plain(24'h3FFFFF, n); check("R2 low below boundary", n, 1);
    plain(24'h400000, n); check("R2 mid at boundary", n, 4);
    plain(24'h9FFFFF, n); check("R3 mid below high boundary", n, 4);
    plain(24'hA00000, n); check("R3 high at boundary", n, 7);
    plain(24'hFFFFFF, n); check("R3 high at top", n, 7);
  endtask

  task automatic t_inverted();
    int n;
    wr(3'd0, 8'hC0); wr(3'd1, 8'h80);
    plain(24'h900000, n); check("R2 high wins inverted", n, 7);
    plain(24'hC80000, n); check("R2 high wins above both", n, 7);
    plain(24'h700000, n); check("R2 low inverted", n, 1);
    wr(3'd0, 8'h40); wr(3'd1, 8'hA0);
  endtask

  task automatic t_wait_line();
    int n;
    dma_cycle(24'h500000, 6, 1'b0, 1'b0, 1'b0, 3'd0, 8'd0, n);
    check("R5 wait longer than count", n, 6);
    dma_cycle(24'h500000, 2, 1'b0, 1'b0, 1'b0, 3'd0, 8'd0, n);
    check("R5 wait shorter than count", n, 4);
    wr(3'd2, 8'd0);
    dma_cycle(24'h100000, 3, 1'b0, 1'b0, 1'b0, 3'd0, 8'd0, n);
    check("R5 wait with zero count", n, 3);
    plain(24'h100000, n); check("R3 zero count", n, 0);
  endtask

  task automatic t_write_timing();
    int n;
    dma_cycle(24'h500000, 0, 1'b0, 1'b1, 1'b0, 3'd3, 8'd1, n);
    check("R6 write during waits keeps count", n, 4);
    plain(24'h500000, n); check("R6 write used next cycle", n, 1);
    dma_cycle(24'h500000, 0, 1'b1, 1'b0, 1'b0, 3'd3, 8'd5, n);
    check("R6 write on t2 clock uses old", n, 1);
    plain(24'h500000, n); check("R6 same-clock write used next", n, 5);
  endtask

  task automatic t_double_t2();
    int n;
    dma_cycle(24'h500000, 0, 1'b0, 1'b0, 1'b1, 3'd0, 8'd0, n);
    check("R7 t2_end while busy ignored", n, 5);
  endtask

  task automatic t_unmapped();
    int n;
    wr(3'd5, 8'hFF); wr(3'd6, 8'h00); wr(3'd7, 8'h55);
    plain(24'h100000, n); check("R8 unmapped write low", n, 0);
    plain(24'h500000, n); check("R8 unmapped write mid", n, 5);
    plain(24'hB00000, n); check("R8 unmapped write high", n, 7);
    wr(3'd2, 8'hFF);
    plain(24'h100000, n); check("R8 count keeps low bits", n, 7);
    wr(3'd4, 8'hFA);
    plain(24'hB00000, n); check("R8 count 0xFA gives 2", n, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    t_reset();
    t_idle_wait();
    t_areas();
    t_inverted();
    t_wait_line();
    t_write_timing();
    t_double_t2();
    t_unmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule